// File: doc/BRIEF.md
# UART Receive FIFO with Threshold Interrupt

This block is the holding stage on the receive side of an asynchronous serial port. A deserializer in front of it hands over complete bytes with a one-cycle valid strobe; the block keeps them in a small first-in first-out store, shows the oldest waiting byte on a registered read-data output, and removes that byte when the processor pulses a read strobe. Several bytes can therefore arrive in a row without the processor reading anything and without any error.

A two-bit level setting selects how many waiting bytes raise the buffer-full interrupt request: a setting of n asks for n+1 bytes. The request follows the fill count both ways. It rises on the cycle the count reaches the level and falls on the cycle the count drops below it. If a byte arrives while every slot is taken and no read frees one in the same cycle, the byte is thrown away and a sticky overrun flag is raised. Dropping the enable empties the store.

Top module: `uart_rx_fifo_thr`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it is released, `fill_cnt` is 0 and `thr_irq` and `ovr_flag` are 0.
- R2: With `en` high, each `rx_valid` pulse raises `fill_cnt` by one on the edge that samples it, as long as fewer than DEPTH (default 4) bytes are held. Up to DEPTH bytes are accepted without a read and without setting `ovr_flag`.
- R3: Whenever `fill_cnt` is non-zero, `rd_data` shows the oldest held byte, and bytes come out in arrival order. A byte written into an empty store shows on `rd_data` one cycle after its strobe. A `rd_stb` sampled with `fill_cnt` non-zero removes the oldest byte and lowers the count by one. A `rd_stb` with an empty store is ignored.
- R4: One cycle after each edge, `thr_irq` is 1 exactly when the count left by that edge is at least `lvl_sel`+1, using the `lvl_sel` sampled at that edge. Setting values 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes. Value 0 raises the request as soon as one byte is held.
- R5: `thr_irq` falls on the same edge at which a read takes the count below the programmed level.
- R6: A byte that arrives while DEPTH bytes are held, with no read in the same cycle, is discarded: the count and the held contents stay unchanged. `ovr_flag` reads 1 from the next cycle on.
- R7: `ovr_flag` stays at 1 until an `ovr_clr` pulse is sampled. A new overrun in the same cycle as `ovr_clr` wins and leaves the flag at 1. Deasserting `en` does not clear the flag.
- R8: An incoming byte together with a read of a non-empty store leaves `fill_cnt` unchanged and keeps the order. When the store is full, the new byte takes the freed slot and no overrun is flagged.
- R9: An edge that samples `en` low empties the store: `fill_cnt` and `thr_irq` read 0 afterwards. While `en` is low, `rx_valid` and `rd_stb` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Receiver enable; low flushes the store |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present on rx_data |
| rx_data | input | DATA_W | Received byte |
| rd_stb | input | 1 | Processor read: removes the oldest byte |
| lvl_sel | input | LVL_W | Interrupt level setting, value plus one bytes |
| ovr_clr | input | 1 | Write-one-to-clear strobe for the overrun flag |
| rd_data | output | DATA_W | Oldest held byte (registered) |
| fill_cnt | output | CNT_W | Number of held bytes |
| thr_irq | output | 1 | Buffer-full interrupt request |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: 8-bit data, four slots and a 2-bit level setting. With these values every level from one byte to a full store can be selected, and a full store is reached within four strobes. That makes the overrun drop, the read-and-write-while-full case and the pointer wrap-around frequent under the mixed random traffic. A queue model checks the count, head byte, request and flag on every cycle, and directed sequences cover the level encoding, set-over-clear priority and flushing while bytes keep arriving.

// File: rtl/rxbuf_pkg.sv
`timescale 1ns/1ps
package rxbuf_pkg;

  // Per-cycle operation on the store, decoded from accepted push and pop.
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

endpackage

// File: rtl/rxbuf_ctrl.sv
`timescale 1ns/1ps
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rx_valid,
  input  logic             rd_stb,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr_nxt,
  output logic             head_bypass,
  output logic             drop,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] fill_nxt
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic             full, empty, do_pop, do_push;
  fifo_op_e         op;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_pop  = en && rd_stb && !empty;
  assign do_push = en && rx_valid && (!full || do_pop);
  assign drop    = en && rx_valid && full && !do_pop;
  assign op      = fifo_op_e'({do_push, do_pop});

  always_comb begin
    wr_nxt   = wr_q;
    rd_nxt   = rd_q;
    fill_nxt = cnt_q;
    if (!en) begin
      wr_nxt   = '0;
      rd_nxt   = '0;
      fill_nxt = '0;
    end else begin
      case (op)
        OP_PUSH: begin
          wr_nxt   = ptr_inc(wr_q);
          fill_nxt = cnt_q + 1'b1;
        end
        OP_POP: begin
          rd_nxt   = ptr_inc(rd_q);
          fill_nxt = cnt_q - 1'b1;
        end
        OP_BOTH: begin
          wr_nxt = ptr_inc(wr_q);
          rd_nxt = ptr_inc(rd_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= fill_nxt;
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
    end
  end

  // The slot being written becomes the head only when the store is empty after the pop.
  assign head_bypass = do_push && (wr_q == rd_nxt);
  assign wr_en       = do_push;
  assign wr_addr     = wr_q;
  assign rd_addr_nxt = rd_nxt;
  assign fill        = cnt_q;

  // R2: count never exceeds the number of slots
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  // R2: a lone accepted byte raises the count by one
  a_r2_push_inc: assert property (@(posedge clk) disable iff (rst)
    (en && rx_valid && !rd_stb && cnt_q < FULL_CNT) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3: a lone read of a non-empty store lowers the count by one
  a_r3_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (en && rd_stb && !rx_valid && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8: byte in plus byte out leaves the count alone
  a_r8_both_hold: assert property (@(posedge clk) disable iff (rst)
    (en && rd_stb && rx_valid && cnt_q != '0) |=> cnt_q == $past(cnt_q));

  // R9: disable flushes the store
  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);

endmodule

// File: rtl/rxbuf_store.sv
`timescale 1ns/1ps
module rxbuf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr_nxt,
  input  logic              head_bypass,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: no reset so the array maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read of the next head, with write-through for a byte landing in an empty store.
  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (head_bypass) rd_data <= wr_data;
    else                  rd_data <= mem[rd_addr_nxt];
  end

  // R3: write-through only happens together with a write to the same slot
  a_r3_bypass_write: assert property (@(posedge clk) disable iff (rst)
    head_bypass |-> (wr_en && wr_addr == rd_addr_nxt));

endmodule

// File: rtl/rxbuf_flags.sv
`timescale 1ns/1ps
module rxbuf_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] fill_nxt,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic             drop,
  input  logic             ovr_clr,
  output logic             thr_irq,
  output logic             ovr_flag
);

  localparam int CMP_W = (CNT_W > LVL_W + 1) ? CNT_W : LVL_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CMP_W-1:0] level;

  assign level = CMP_W'(lvl_sel) + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_irq  <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      thr_irq <= (CMP_W'(fill_nxt) >= level);
      if (drop)         ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  // R4: request matches the held count against the level sampled one edge earlier
  a_r4_irq_level: assert property (@(posedge clk) disable iff (rst)
    thr_irq == (CMP_W'(fill) >= CMP_W'($past(lvl_sel)) + 1'b1));

  // R6: a dropped byte always leaves the flag set
  a_r6_drop_sets: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr_flag);

  // R6: a drop can only occur while the store is full
  a_r6_drop_full: assert property (@(posedge clk) disable iff (rst)
    drop |-> fill == FULL_CNT);

  // R7: flag is sticky without a clear strobe
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

endmodule

// File: rtl/uart_rx_fifo_thr.sv
`timescale 1ns/1ps
module uart_rx_fifo_thr #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_stb,
  input  logic [LVL_W-1:0]  lvl_sel,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              thr_irq,
  output logic              ovr_flag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             wr_en, head_bypass, drop;
  logic [PTR_W-1:0] wr_addr, rd_addr_nxt;
  logic [CNT_W-1:0] fill_nxt;

  rxbuf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .rx_valid   (rx_valid),
    .rd_stb     (rd_stb),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr_nxt(rd_addr_nxt),
    .head_bypass(head_bypass),
    .drop       (drop),
    .fill       (fill_cnt),
    .fill_nxt   (fill_nxt)
  );

  rxbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (rx_data),
    .rd_addr_nxt(rd_addr_nxt),
    .head_bypass(head_bypass),
    .rd_data    (rd_data)
  );

  rxbuf_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .fill    (fill_cnt),
    .fill_nxt(fill_nxt),
    .lvl_sel (lvl_sel),
    .drop    (drop),
    .ovr_clr (ovr_clr),
    .thr_irq (thr_irq),
    .ovr_flag(ovr_flag)
  );

  // R9: disable also withdraws the request
  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !thr_irq);

  // R8: a full store that reads and receives together keeps the flag unchanged
  a_r8_full_swap: assert property (@(posedge clk) disable iff (rst)
    (en && rx_valid && rd_stb && !ovr_clr && fill_cnt == CNT_W'(DEPTH))
      |=> (fill_cnt == CNT_W'(DEPTH) && ovr_flag == $past(ovr_flag)));

endmodule

// File: tb/test_uart_rx_fifo_thr.sv
`timescale 1ns/1ps
module test_uart_rx_fifo_thr;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int LVL_W  = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              b_rst = 1'b1;
  logic              b_en = 1'b0;
  logic              b_rxv = 1'b0;
  logic [DATA_W-1:0] b_data = '0;
  logic              b_rd = 1'b0;
  logic [LVL_W-1:0]  b_lvl = '0;
  logic              b_clr = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  fill_cnt;
  logic              thr_irq, ovr_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_fifo_thr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_uart_rx_fifo_thr (
    .clk     (clk),
    .rst     (b_rst),
    .en      (b_en),
    .rx_valid(b_rxv),
    .rx_data (b_data),
    .rd_stb  (b_rd),
    .lvl_sel (b_lvl),
    .ovr_clr (b_clr),
    .rd_data (rd_data),
    .fill_cnt(fill_cnt),
    .thr_irq (thr_irq),
    .ovr_flag(ovr_flag)
  );

  // Behavioural reference: a queue of held bytes plus two flags.
  logic [DATA_W-1:0] m_q[$];
  bit m_irq = 1'b0;
  bit m_ovr = 1'b0;

  always @(posedge clk) begin
    int n;
    bit pop, full;
    if (b_rst) begin
      m_q.delete();
      m_irq = 1'b0;
      m_ovr = 1'b0;
    end else begin
      n    = m_q.size();
      pop  = b_en && b_rd && n > 0;
      full = (n == DEPTH);
      if (b_en && b_rxv && full && !pop) m_ovr = 1'b1;
      else if (b_clr)                    m_ovr = 1'b0;
      if (!b_en) m_q.delete();
      else begin
        if (pop) void'(m_q.pop_front());
        if (b_rxv && (!full || pop)) m_q.push_back(b_data);
      end
      m_irq = (m_q.size() >= int'(b_lvl) + 1);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!b_rst && !done) begin
      chk("R2 fill_cnt", int'(fill_cnt), m_q.size());
      chk("R4 thr_irq", int'(thr_irq), int'(m_irq));
      chk("R6 ovr_flag", int'(ovr_flag), int'(m_ovr));
      if (m_q.size() > 0) chk("R3 rd_data", int'(rd_data), int'(m_q[0]));
    end
  end

  // One clock: apply inputs, let one edge consume them, return after the negedge checks.
  task automatic cyc(input logic v, input logic [DATA_W-1:0] d, input logic rd, input logic clr);
    b_rxv  = v;
    b_data = d;
    b_rd   = rd;
    b_clr  = clr;
    @(negedge clk);
    #1;
    b_rxv = 1'b0;
    b_rd  = 1'b0;
    b_clr = 1'b0;
  endtask

  initial begin
    #(1_000_000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    b_rst = 1'b0;
    b_en  = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 fill after reset", int'(fill_cnt), 0);
    chk("R1 irq after reset", int'(thr_irq), 0);
    chk("R1 ovr after reset", int'(ovr_flag), 0);

    // Level setting 0: one byte is enough.
    b_lvl = 2'd0;
    cyc(1, 8'h11, 0, 0);
    chk("R4 level0 irq", int'(thr_irq), 1);
    chk("R3 first byte visible", int'(rd_data), 8'h11);
    cyc(0, 0, 1, 0);
    chk("R5 irq drops after read", int'(thr_irq), 0);
    chk("R3 count after read", int'(fill_cnt), 0);
    cyc(0, 0, 1, 0);
    chk("R3 read on empty ignored", int'(fill_cnt), 0);

    // Level setting 3: four bytes needed; then overrun.
    b_lvl = 2'd3;
    cyc(1, 8'hA1, 0, 0);
    cyc(1, 8'hA2, 0, 0);
    cyc(1, 8'hA3, 0, 0);
    chk("R4 level3 three bytes", int'(thr_irq), 0);
    cyc(1, 8'hA4, 0, 0);
    chk("R4 level3 four bytes", int'(thr_irq), 1);
    chk("R2 four accepted", int'(fill_cnt), 4);
    chk("R2 no overrun at four", int'(ovr_flag), 0);
    cyc(1, 8'hA5, 0, 0);
    chk("R6 overrun set", int'(ovr_flag), 1);
    chk("R6 count kept", int'(fill_cnt), 4);
    chk("R6 head kept", int'(rd_data), 8'hA1);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R7 flag sticky", int'(ovr_flag), 1);

    // Read and write while full.
    cyc(1, 8'hB0, 1, 0);
    chk("R8 count unchanged", int'(fill_cnt), 4);
    chk("R8 head advanced", int'(rd_data), 8'hA2);
    cyc(0, 0, 0, 1);
    chk("R7 clear works", int'(ovr_flag), 0);
    cyc(1, 8'hB1, 1, 0);
    chk("R8 no overrun on swap", int'(ovr_flag), 0);
    chk("R8 order after swap", int'(rd_data), 8'hA3);
    b_lvl = 2'd2;
    cyc(0, 0, 1, 0);
    chk("R5 below level 3 bytes", int'(thr_irq), 1);
    cyc(0, 0, 1, 0);
    chk("R5 below level drops", int'(thr_irq), 0);
    chk("R3 order B0", int'(rd_data), 8'hB0);

    // Refill, then overrun and clear together: set wins.
    cyc(1, 8'hC0, 0, 0);
    cyc(1, 8'hC1, 0, 0);
    chk("R2 full again", int'(fill_cnt), 4);
    cyc(1, 8'hC2, 0, 1);
    chk("R7 set beats clear", int'(ovr_flag), 1);

    // Disable with traffic.
    b_en = 1'b0;
    cyc(1, 8'hD0, 1, 0);
    chk("R9 flushed", int'(fill_cnt), 0);
    chk("R9 irq off", int'(thr_irq), 0);
    chk("R7 disable keeps flag", int'(ovr_flag), 1);
    cyc(1, 8'hD1, 0, 0);
    chk("R9 byte ignored while off", int'(fill_cnt), 0);
    b_en = 1'b1;
    cyc(0, 0, 0, 1);
    cyc(1, 8'hE0, 0, 0);
    chk("R9 works after enable", int'(rd_data), 8'hE0);

    // Mixed random traffic, compared every cycle by the model.
    for (int i = 0; i < 4000; i++) begin
      if (i % 50 == 0) b_lvl = LVL_W'($urandom);
      b_en = ($urandom_range(0, 63) != 0);
      cyc($urandom_range(0, 1) == 1, DATA_W'($urandom),
          $urandom_range(0, 9) < 4, $urandom_range(0, 15) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule